// File: doc/BRIEF.md
# Rotating Test-Pattern Buffer

This block keeps a small set of 48-bit test words and, when asked, pushes them into the output word stream in place of hit data. Software loads it one byte at a time through an 8-bit configuration field. Each byte is qualified by a rising edge on a new-data strobe. A write pointer that moves on by itself places each byte. The bytes of a word are filled from the least significant end. Once a word is full the pointer moves to the next word, and after the last word it wraps back to the first. Repeated loading therefore reaches every cell without any address.

A replay request starts a group that reads every stored word in order, starting at word 0. The downstream formatter grants word slots. Each grant taken during a group produces one word on the output one cycle later, with its valid flag set. A group always holds exactly eight words, so the stream it adds is a whole multiple of eight. If a request arrives while a group is running, it is remembered, and a new group begins as soon as the current one has finished.

The controller has two states. ST_IDLE moves to ST_SEND when a request is seen. ST_SEND stays in ST_SEND while words remain. On the grant of the last word, ST_SEND either returns to ST_IDLE, or restarts in ST_SEND at word 0 when a request is pending or present.

Top module: `tpat_replay_buffer`

## Requirements
- R1: After reset, word_valid is 0, all eight stored words read as zero, and the write pointer sits at word 0, byte lane 0.
- R2: Each accepted byte lands in byte lane k of the current word, at bits [8k+7:8k], with k running from 0 to 5. The first byte of a word fills the least significant lane.
- R3: After lane 5 is written, the pointer moves to lane 0 of the next word. After word 7 it wraps to word 0, so the 49th accepted byte overwrites word 0, lane 0.
- R4: A byte is accepted only in a cycle where cfg_strobe is 1 and was 0 in the cycle before. A strobe held high writes once.
- R5: In ST_SEND, every cycle with slot_grant = 1 yields, on the next cycle, word_valid = 1 and the next stored word in index order.
- R6: With slot_grant = 0, word_valid is 0 on the next cycle and the read position does not advance.
- R7: A group emits exactly eight words, then the block returns to ST_IDLE unless a request is pending. Outside a group, word_valid stays 0.
- R8: A request seen during ST_SEND is held. The next group starts on the cycle after the last word of the current group, with no idle cycle between the groups.
- R9: A byte written in the same cycle that its word is granted is not visible in that word. The emitted word holds the content from before that edge.
- R10: Every group starts at word 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_byte | input | 8 | Configuration data byte |
| cfg_strobe | input | 1 | New-data strobe, acted on at its rising edge |
| replay_req | input | 1 | Request to send the test pattern |
| slot_grant | input | 1 | Word slot granted by the formatter |
| word_out | output | 48 | Replayed test word |
| word_valid | output | 1 | word_out carries a replayed word |

## Verification
Two things can happen in the same cycle: loading a byte, and replaying the word that byte belongs to. The bench sends strobe edges while a group is running and grants are being taken, including edges that hit the word being emitted at that moment. A bench model applies the write only after capturing the emitted word. Every output word is compared with that model, which settles whether old or new content appeared. A request that overlaps the last grant of a group is provoked in the same way, so that the restart path and the hold path are both checked against the model.

// File: rtl/tpb_pkg.sv
package tpb_pkg;
    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_SEND = 1'b1
    } replay_state_t;
endpackage

// File: rtl/tpb_byte_loader.sv
module tpb_byte_loader #(
    parameter int WORDS = 8,
    parameter int BYTES = 6,
    localparam int IDX_W  = $clog2(WORDS),
    localparam int LANE_W = $clog2(BYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              strobe,
    output logic              wr_en,
    output logic [IDX_W-1:0]  wr_word,
    output logic [LANE_W-1:0] wr_lane
);
    localparam logic [LANE_W-1:0] LAST_LANE = LANE_W'(BYTES - 1);
    localparam logic [IDX_W-1:0]  LAST_WORD = IDX_W'(WORDS - 1);

    logic strobe_q;

    // Rising-edge qualification of the data strobe.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) strobe_q <= 1'b0;
        else        strobe_q <= strobe;
    end

    assign wr_en = strobe && !strobe_q;

    // Rotating pointer: lane first, then word, with wrap.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_lane <= '0;
            wr_word <= '0;
        end else if (wr_en) begin
            if (wr_lane == LAST_LANE) begin
                wr_lane <= '0;
                wr_word <= (wr_word == LAST_WORD) ? '0 : wr_word + 1'b1;
            end else begin
                wr_lane <= wr_lane + 1'b1;
            end
        end
    end

    assert_single_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> !wr_en);
    assert_lane_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_lane <= LAST_LANE);
    assert_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_lane == LAST_LANE && wr_word == LAST_WORD)
        |=> (wr_word == '0 && wr_lane == '0));
endmodule

// File: rtl/tpb_store.sv
module tpb_store #(
    parameter int WORDS  = 8,
    parameter int WORD_W = 48,
    parameter int BYTE_W = 8,
    localparam int BYTES  = WORD_W / BYTE_W,
    localparam int IDX_W  = $clog2(WORDS),
    localparam int LANE_W = $clog2(BYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_word,
    input  logic [LANE_W-1:0] wr_lane,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [WORD_W-1:0] rd_word
);
    logic [WORD_W-1:0] mem_q [WORDS];

    for (genvar w = 0; w < WORDS; w++) begin : g_word
        for (genvar l = 0; l < BYTES; l++) begin : g_lane
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)
                    mem_q[w][l*BYTE_W +: BYTE_W] <= '0;
                else if (wr_en && wr_word == IDX_W'(w) && wr_lane == LANE_W'(l))
                    mem_q[w][l*BYTE_W +: BYTE_W] <= wr_data;
            end

            assert_lane_store_R2: assert property (@(posedge clk) disable iff (!rst_n)
                (wr_en && wr_word == IDX_W'(w) && wr_lane == LANE_W'(l))
                |=> mem_q[w][l*BYTE_W +: BYTE_W] == $past(wr_data));
        end
    end

    assign rd_word = mem_q[rd_idx];
endmodule

// File: rtl/tpb_replay_fsm.sv
module tpb_replay_fsm
    import tpb_pkg::*;
#(
    parameter int WORDS = 8,
    localparam int IDX_W = $clog2(WORDS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req,
    input  logic             grant,
    output logic [IDX_W-1:0] rd_idx,
    output logic             emit
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(WORDS - 1);

    replay_state_t    st_q, st_d;
    logic [IDX_W-1:0] idx_q, idx_d;
    logic             pend_q, pend_d;

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q   <= ST_IDLE;
            idx_q  <= '0;
            pend_q <= 1'b0;
        end else begin
            st_q   <= st_d;
            idx_q  <= idx_d;
            pend_q <= pend_d;
        end
    end

    // Next-state logic.
    always_comb begin
        st_d   = st_q;
        idx_d  = idx_q;
        pend_d = pend_q;
        unique case (st_q)
            ST_IDLE: begin
                if (req) st_d = ST_SEND;
            end
            ST_SEND: begin
                if (grant) begin
                    if (idx_q == LAST_IDX) begin
                        idx_d = '0;
                        if (pend_q || req) pend_d = 1'b0;
                        else               st_d   = ST_IDLE;
                    end else begin
                        idx_d = idx_q + 1'b1;
                        if (req) pend_d = 1'b1;
                    end
                end else if (req) begin
                    pend_d = 1'b1;
                end
            end
        endcase
    end

    // Outputs.
    always_comb begin
        rd_idx = idx_q;
        emit   = (st_q == ST_SEND) && grant;
    end

    assert_idle_at_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        st_q == ST_IDLE |-> (idx_q == '0 && !pend_q));
    assert_group_end_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_SEND && grant && idx_q == LAST_IDX && !pend_q && !req)
        |=> st_q == ST_IDLE);
    assert_held_request_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_SEND && grant && idx_q == LAST_IDX && pend_q)
        |=> (st_q == ST_SEND && idx_q == '0));
    assert_start_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_IDLE && req) |=> (st_q == ST_SEND && idx_q == '0));
    assert_hold_no_grant_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_SEND && !grant) |=> (st_q == ST_SEND && $stable(idx_q)));
endmodule

// File: rtl/tpat_replay_buffer.sv
module tpat_replay_buffer #(
    parameter int WORDS  = 8,
    parameter int WORD_W = 48,
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BYTE_W-1:0] cfg_byte,
    input  logic              cfg_strobe,
    input  logic              replay_req,
    input  logic              slot_grant,
    output logic [WORD_W-1:0] word_out,
    output logic              word_valid
);
    localparam int BYTES  = WORD_W / BYTE_W;
    localparam int IDX_W  = $clog2(WORDS);
    localparam int LANE_W = $clog2(BYTES);

    logic              wr_en;
    logic [IDX_W-1:0]  wr_word;
    logic [LANE_W-1:0] wr_lane;
    logic [IDX_W-1:0]  rd_idx;
    logic [WORD_W-1:0] rd_word;
    logic              emit;

    tpb_byte_loader #(.WORDS(WORDS), .BYTES(BYTES)) u_loader (
        .clk    (clk),
        .rst_n  (rst_n),
        .strobe (cfg_strobe),
        .wr_en  (wr_en),
        .wr_word(wr_word),
        .wr_lane(wr_lane)
    );

    tpb_store #(.WORDS(WORDS), .WORD_W(WORD_W), .BYTE_W(BYTE_W)) u_store (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_en),
        .wr_word(wr_word),
        .wr_lane(wr_lane),
        .wr_data(cfg_byte),
        .rd_idx (rd_idx),
        .rd_word(rd_word)
    );

    tpb_replay_fsm #(.WORDS(WORDS)) u_fsm (
        .clk   (clk),
        .rst_n (rst_n),
        .req   (replay_req),
        .grant (slot_grant),
        .rd_idx(rd_idx),
        .emit  (emit)
    );

    // Registered output word and flag.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            word_valid <= 1'b0;
            word_out   <= '0;
        end else begin
            word_valid <= emit;
            if (emit) word_out <= rd_word;
        end
    end

    assert_valid_needs_grant_R5: assert property (@(posedge clk) disable iff (!rst_n)
        word_valid |-> $past(slot_grant));
    assert_no_grant_no_word_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !slot_grant |=> !word_valid);
endmodule

// File: tb/tb_tpat_replay_buffer.sv
module tb_tpat_replay_buffer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  cfg_byte = '0;
    logic        cfg_strobe = 1'b0;
    logic        replay_req = 1'b0;
    logic        slot_grant = 1'b0;
    logic [47:0] word_out;
    logic        word_valid;

    always #5 clk = ~clk;

    tpat_replay_buffer dut (
        .clk(clk), .rst_n(rst_n), .cfg_byte(cfg_byte), .cfg_strobe(cfg_strobe),
        .replay_req(replay_req), .slot_grant(slot_grant),
        .word_out(word_out), .word_valid(word_valid)
    );

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // Bench model state.
    logic [47:0] em [8];
    int  wp, bp;
    bit  prev_s, busy, pend;
    int  idx;
    bit  exp_valid;
    logic [47:0] exp_word;

    function automatic void model_reset();
        for (int i = 0; i < 8; i++) em[i] = '0;
        wp = 0; bp = 0; prev_s = 0; busy = 0; pend = 0; idx = 0;
    endfunction

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [47:0] act, input logic [47:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic cyc(input bit s, input logic [7:0] b, input bit rq,
                       input bit g, input string tag);
        cfg_strobe = s; cfg_byte = b; replay_req = rq; slot_grant = g;
        @(posedge clk);
        exp_valid = busy && g;
        exp_word  = em[idx];
        if (s && !prev_s) begin
            em[wp][bp*8 +: 8] = b;
            if (bp == 5) begin bp = 0; wp = (wp + 1) % 8; end
            else bp++;
        end
        prev_s = s;
        if (busy) begin
            if (g) begin
                if (idx == 7) begin
                    idx = 0;
                    if (pend || rq) pend = 0;
                    else busy = 0;
                end else begin
                    idx++;
                    if (rq) pend = 1;
                end
            end else if (rq) pend = 1;
        end else if (rq) busy = 1;
        #1;
        chk(word_valid == exp_valid, tag, "word_valid", 48'(word_valid), 48'(exp_valid));
        if (exp_valid)
            chk(word_out == exp_word, tag, "word_out", word_out, exp_word);
    endtask

    task automatic load_byte(input logic [7:0] b, input string tag);
        cyc(1, b, 0, 0, tag);
        cyc(0, b, 0, 0, tag);
    endtask

    task automatic replay(input string tag, input bit gaps);
        cyc(0, 8'h00, 1, 0, tag);
        for (int n = 0; n < 100 && busy; n++)
            cyc(0, 8'h00, 0, gaps ? 1'($urandom % 2) : 1'b1, tag);
        cyc(0, 8'h00, 0, 0, tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h1234_abcd));
        model_reset();
        repeat (3) @(posedge clk);
        #1;
        chk(word_valid == 1'b0, "R1", "word_valid in reset", 48'(word_valid), 48'h0);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: contents zero after reset
        replay("R1", 0);
        // R2: six bytes fill word 0, least significant first
        for (int k = 0; k < 6; k++) load_byte(8'h11 + 8'(k), "R2");
        replay("R2", 0);
        // R4: a strobe held high writes once
        cyc(1, 8'hA5, 0, 0, "R4");
        cyc(1, 8'h5A, 0, 0, "R4");
        cyc(1, 8'h3C, 0, 0, "R4");
        cyc(0, 8'h00, 0, 0, "R4");
        replay("R4", 0);
        // R3: fill the rest and wrap
        for (int k = 0; k < 49; k++) load_byte(8'($urandom), "R3");
        replay("R3", 0);
        // R10: order from word 0 with distinct words
        replay("R10", 0);
        // R6: gaps in granted slots
        replay("R6", 1);
        replay("R5", 1);
        // R8: request during replay, and one at the last grant
        cyc(0, 8'h00, 1, 0, "R8");
        for (int n = 0; n < 3; n++) cyc(0, 8'h00, 0, 1, "R8");
        cyc(0, 8'h00, 1, 1, "R8");
        for (int n = 0; n < 40 && busy; n++)
            cyc(0, 8'h00, (idx == 7) ? 1'b1 : 1'b0, 1, "R8");
        cyc(0, 8'h00, 0, 0, "R8");
        // R9: writes while the group runs
        cyc(0, 8'h00, 1, 0, "R9");
        for (int n = 0; n < 60 && busy; n++)
            cyc(n[0], 8'($urandom), 0, 1, "R9");
        cyc(0, 8'h00, 0, 0, "R9");
        // R7: random mix
        for (int n = 0; n < 4000; n++)
            cyc(1'($urandom % 2), 8'($urandom), ($urandom % 16) == 0,
                1'($urandom % 4 != 0), "R7");
        for (int n = 0; n < 40 && busy; n++) cyc(0, 8'h00, 0, 1, "R7");
        cyc(0, 8'h00, 0, 0, "R7");
        cyc(0, 8'h00, 0, 1, "R7");
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule